// File: doc/BRIEF.md
# Exception Status Recorder

This block files the details of a program exception into a bank of status slots. A single-cycle event arrives with a kind, the pipe that issued the instruction, a variant mode, the faulting PC, the base PC of the instruction packet, an effective address, up to four store-data words with a length, and a sub-code. The block chooses the slot from the kind, the pipe and the mode. In that slot it writes a status word and, when the kind calls for them, the PC and address registers. It also sets the matching summary flag. Store data is placed right-aligned in a shared group of four data registers.

A software clear drops the valid bits and zeroes the summary flags. Division events also OR their sub-code into a trap accumulator. An event whose kind has no recording rule raises an error pulse and writes nothing. All results appear in the cycle after the event.

Top module: `exc_status_rec`

## Requirements
- R1: Precise kinds (1 register, 2 instruction access, 3 other precise) record into slot 0. Kinds 1 and 2 store the sub-code in status bits [12:9], and kind 3 stores zero there. The PC register of slot 0 is written unless mode is 1 (alternate), in which case it keeps its value.
- R2: Division (kind 4) and commit (kind 5) use slot 0 from pipe 0 and slot 1 from pipe 1. Both write the PC. In mode 1 they always use slot 0. From pipes 2 or 3 outside mode 1 they write no slot and leave the summary flags unchanged.
- R3: A division event ORs its sub-code into the trap accumulator output, whatever slot it uses.
- R4: A store error (kind 6) records into slot 14 with address-valid clear. An access error (kind 7) records into slot 15, writes the slot's address register and sets address-valid.
- R5: Data access exception (kind 8), MMU miss (kind 9) and misalignment (kind 10) write the address and PC registers and set address-valid. They use slot 8 from pipe 0 and slot 9 from any other pipe. In mode 1 they always use slot 8. Only kind 8 stores its sub-code.
- R6: For kinds 8 to 10, when the length is non-zero and the mode is not 1, data word i goes to data register 4-L+i, where L is the length and values above 4 count as 4. Status bits [4:3] then hold 4-L and status bit 2 (data-valid) is set. Otherwise no data register changes.
- R7: Each recording overwrites the whole status word. Address-valid (bit 1) and data-valid (bit 2) are cleared whenever that event does not record an address or data.
- R8: In mode 2 (packet) the PC register receives the packet base PC instead of the faulting PC. Modes 0 and 3 use the faulting PC.
- R9: The software clear zeroes all summary flags and clears the valid bit (bit 0) of slots 0 to 2 and 8 to 15. The other status bits are kept. An event in the same cycle still records, and its slot ends up valid with its flag set.
- R10: A recording sets status bit 0 (valid), puts the kind in bits [8:5] and sets the summary flag bit that has the slot's index. It is visible in the cycle after the strobe.
- R11: An event of kind 0 or 11 to 15 drives the error output high for exactly the next cycle and changes no slot or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe, one cycle |
| ev_kind | input | 4 | Exception kind code |
| ev_pipe | input | 2 | Issuing pipe, 0 and 1 are the integer pipes |
| ev_mode | input | 2 | 0 standard, 1 alternate, 2 packet PC, 3 as 0 |
| ev_pc | input | AW | Faulting instruction PC |
| ev_pkt_pc | input | AW | Packet base PC |
| ev_addr | input | AW | Effective address |
| ev_len | input | 3 | Store data length in words |
| ev_data | input | 4*DW | Store data words, word 0 lowest |
| ev_sub | input | SUBW | Sub-code |
| sw_clear | input | 1 | Software clear strobe |
| st_words | output | NSLOT*STW | Status words, slot 0 lowest |
| pc_regs | output | NSLOT*AW | PC registers per slot |
| addr_regs | output | NSLOT*AW | Address registers per slot |
| data_regs | output | 4*DW | Shared store-data group |
| sum_flags | output | NSLOT | Summary flag bit per slot |
| trap_acc | output | SUBW | Division trap-type accumulator |
| bad_kind | output | 1 | Unsupported kind pulse |

## Verification
Every cycle, the checker confirms several rules: a precise event validates slot 0, an access error fills slot 15's address, a clear with no event empties the flags, alternate-mode data events never set data-valid, and an unsupported kind pulses the error without touching the flags. Other behaviour needs the bench's scenarios: the right-aligned data placement and its length clamp, the pipe-dependent slot choice, PC suppression in alternate mode, the packet-PC substitution, trap accumulation across events, and a clear that coincides with an event.

// File: rtl/exc_rec_pkg.sv
package exc_rec_pkg;
   localparam logic [3:0] K_REG    = 4'd1;
   localparam logic [3:0] K_IACC   = 4'd2;
   localparam logic [3:0] K_PREC   = 4'd3;
   localparam logic [3:0] K_DIV    = 4'd4;
   localparam logic [3:0] K_COMMIT = 4'd5;
   localparam logic [3:0] K_STERR  = 4'd6;
   localparam logic [3:0] K_ACCERR = 4'd7;
   localparam logic [3:0] K_DACC   = 4'd8;
   localparam logic [3:0] K_MMU    = 4'd9;
   localparam logic [3:0] K_ALIGN  = 4'd10;

   localparam logic [1:0] M_ALT = 2'd1;
   localparam logic [1:0] M_PKT = 2'd2;

   localparam int B_VALID = 0;
   localparam int B_AV    = 1;
   localparam int B_DV    = 2;
   localparam int B_IDX   = 3;
   localparam int B_KIND  = 5;
   localparam int B_SUB   = 9;

   typedef struct packed {
      logic       hit;
      logic [3:0] slot;
      logic       wr_pc;
      logic       wr_addr;
      logic       wr_data;
      logic       keep_sub;
      logic       div_acc;
      logic       err;
   } sel_t;
endpackage

// File: rtl/exc_slot_sel.sv
module exc_slot_sel
   import exc_rec_pkg::*;
(
   input  logic [3:0] kind,
   input  logic [1:0] pipe,
   input  logic [1:0] mode,
   input  logic [2:0] len,
   output sel_t       sel
);
   logic alt;
   assign alt = (mode == M_ALT);

   always_comb begin
      sel = '0;
      case (kind)
         K_REG, K_IACC, K_PREC: begin
            sel.hit      = 1'b1;
            sel.slot     = 4'd0;
            sel.wr_pc    = !alt;
            sel.keep_sub = (kind != K_PREC);
         end
         K_DIV, K_COMMIT: begin
            sel.div_acc = (kind == K_DIV);
            if (alt || pipe == 2'd0) begin
               sel.hit  = 1'b1;
               sel.slot = 4'd0;
            end else if (pipe == 2'd1) begin
               sel.hit  = 1'b1;
               sel.slot = 4'd1;
            end
            sel.wr_pc = sel.hit;
         end
         K_STERR: begin
            sel.hit  = 1'b1;
            sel.slot = 4'd14;
         end
         K_ACCERR: begin
            sel.hit     = 1'b1;
            sel.slot    = 4'd15;
            sel.wr_addr = 1'b1;
         end
         K_DACC, K_MMU, K_ALIGN: begin
            sel.hit      = 1'b1;
            sel.slot     = (alt || pipe == 2'd0) ? 4'd8 : 4'd9;
            sel.wr_addr  = 1'b1;
            sel.wr_pc    = 1'b1;
            sel.wr_data  = (len != 3'd0) && !alt;
            sel.keep_sub = (kind == K_DACC);
         end
         default: sel.err = 1'b1;
      endcase
   end
endmodule

// File: rtl/exc_data_align.sv
module exc_data_align #(
   parameter int DW = 32
) (
   input  logic [2:0]      len,
   input  logic [4*DW-1:0] words,
   output logic [1:0]      start,
   output logic [3:0]      word_en,
   output logic [4*DW-1:0] aligned
);
   logic [2:0] eff_len;
   logic [2:0] start_w;

   assign eff_len = (len > 3'd4) ? 3'd4 : len;
   assign start_w = 3'd4 - eff_len;
   assign start   = start_w[1:0];

   for (genvar j = 0; j < 4; j++) begin : g_word
      always_comb begin
         int k;
         k = j - int'(start_w);
         word_en[j] = (len != 3'd0) && (k >= 0);
         aligned[j*DW +: DW] = '0;
         for (int m = 0; m < 4; m++)
            if (m == k) aligned[j*DW +: DW] = words[m*DW +: DW];
      end
   end
endmodule

// File: rtl/exc_slot_bank.sv
module exc_slot_bank #(
   parameter int NSLOT = 16,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int STW   = 13,
   localparam int SLW  = $clog2(NSLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [SLW-1:0]     slot,
   input  logic [STW-1:0]     st_new,
   input  logic               pc_we,
   input  logic [AW-1:0]      pc_new,
   input  logic               addr_we,
   input  logic [AW-1:0]      addr_new,
   input  logic [3:0]         data_we,
   input  logic [4*DW-1:0]    data_new,
   input  logic               clr,
   output logic [NSLOT*STW-1:0] st_words,
   output logic [NSLOT*AW-1:0]  pc_regs,
   output logic [NSLOT*AW-1:0]  addr_regs,
   output logic [4*DW-1:0]      data_regs,
   output logic [NSLOT-1:0]     sum_flags
);
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam bit CLR_OK = (g <= 2) || (g >= 8 && g <= 15);
      logic hit;
      assign hit = we && (slot == SLW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_words[g*STW +: STW] <= '0;
            pc_regs[g*AW +: AW]    <= '0;
            addr_regs[g*AW +: AW]  <= '0;
         end else begin
            if (hit)
               st_words[g*STW +: STW] <= st_new;
            else if (clr && CLR_OK)
               st_words[g*STW] <= 1'b0;
            if (hit && pc_we)   pc_regs[g*AW +: AW]   <= pc_new;
            if (hit && addr_we) addr_regs[g*AW +: AW] <= addr_new;
         end
      end
   end

   for (genvar j = 0; j < 4; j++) begin : g_data
      always_ff @(posedge clk) begin
         if (!rst_n)           data_regs[j*DW +: DW] <= '0;
         else if (data_we[j])  data_regs[j*DW +: DW] <= data_new[j*DW +: DW];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sum_flags <= '0;
      else        sum_flags <= (clr ? '0 : sum_flags)
                             | (we ? (NSLOT'(1) << slot) : '0);
   end
endmodule

// File: rtl/exc_status_rec.sv
module exc_status_rec
   import exc_rec_pkg::*;
#(
   parameter int NSLOT = 16,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int SUBW  = 4,
   localparam int STW  = B_SUB + SUBW,
   localparam int SLW  = $clog2(NSLOT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_valid,
   input  logic [3:0]           ev_kind,
   input  logic [1:0]           ev_pipe,
   input  logic [1:0]           ev_mode,
   input  logic [AW-1:0]        ev_pc,
   input  logic [AW-1:0]        ev_pkt_pc,
   input  logic [AW-1:0]        ev_addr,
   input  logic [2:0]           ev_len,
   input  logic [4*DW-1:0]      ev_data,
   input  logic [SUBW-1:0]      ev_sub,
   input  logic                 sw_clear,
   output logic [NSLOT*STW-1:0] st_words,
   output logic [NSLOT*AW-1:0]  pc_regs,
   output logic [NSLOT*AW-1:0]  addr_regs,
   output logic [4*DW-1:0]      data_regs,
   output logic [NSLOT-1:0]     sum_flags,
   output logic [SUBW-1:0]      trap_acc,
   output logic                 bad_kind
);
   if (NSLOT < 16) begin : g_bad_nslot
      $error("exc_status_rec: NSLOT must be at least 16");
   end
   if (SUBW < 1) begin : g_bad_subw
      $error("exc_status_rec: SUBW must be positive");
   end

   sel_t            sel;
   logic [1:0]      d_start;
   logic [3:0]      d_en;
   logic [4*DW-1:0] d_aligned;
   logic            wr;
   logic            wr_data;
   logic [STW-1:0]  st_new;

   exc_slot_sel u_sel (
      .kind (ev_kind),
      .pipe (ev_pipe),
      .mode (ev_mode),
      .len  (ev_len),
      .sel  (sel)
   );

   exc_data_align #(.DW(DW)) u_align (
      .len     (ev_len),
      .words   (ev_data),
      .start   (d_start),
      .word_en (d_en),
      .aligned (d_aligned)
   );

   assign wr      = ev_valid && sel.hit;
   assign wr_data = wr && sel.wr_data;

   always_comb begin
      st_new = '0;
      st_new[B_VALID]          = 1'b1;
      st_new[B_AV]             = sel.wr_addr;
      st_new[B_DV]             = sel.wr_data;
      st_new[B_IDX +: 2]       = sel.wr_data ? d_start : 2'd0;
      st_new[B_KIND +: 4]      = ev_kind;
      st_new[B_SUB +: SUBW]    = sel.keep_sub ? ev_sub : '0;
   end

   exc_slot_bank #(
      .NSLOT(NSLOT), .AW(AW), .DW(DW), .STW(STW)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr),
      .slot      (SLW'(sel.slot)),
      .st_new    (st_new),
      .pc_we     (sel.wr_pc),
      .pc_new    ((ev_mode == M_PKT) ? ev_pkt_pc : ev_pc),
      .addr_we   (sel.wr_addr),
      .addr_new  (ev_addr),
      .data_we   (wr_data ? d_en : 4'b0),
      .data_new  (d_aligned),
      .clr       (sw_clear),
      .st_words  (st_words),
      .pc_regs   (pc_regs),
      .addr_regs (addr_regs),
      .data_regs (data_regs),
      .sum_flags (sum_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_acc <= '0;
         bad_kind <= 1'b0;
      end else begin
         if (ev_valid && sel.div_acc) trap_acc <= trap_acc | ev_sub;
         bad_kind <= ev_valid && sel.err;
      end
   end
endmodule

// File: rtl/exc_status_rec_chk.sv
module exc_status_rec_chk #(
   parameter int NSLOT = 16,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int SUBW  = 4,
   localparam int STW  = 9 + SUBW
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ev_valid,
   input logic [3:0]           ev_kind,
   input logic [1:0]           ev_mode,
   input logic [AW-1:0]        ev_addr,
   input logic                 sw_clear,
   input logic [NSLOT*STW-1:0] st_words,
   input logic [NSLOT*AW-1:0]  addr_regs,
   input logic [NSLOT-1:0]     sum_flags,
   input logic                 bad_kind
);
   logic unsupported;
   assign unsupported = (ev_kind == 4'd0) || (ev_kind > 4'd10);

   p_precise_slot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind >= 4'd1 && ev_kind <= 4'd3)
      |=> (sum_flags[0] && st_words[0]));

   p_accerr_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == 4'd7)
      |=> (st_words[15*STW + 1] && addr_regs[15*AW +: AW] == $past(ev_addr)));

   p_alt_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_mode == 2'd1 && ev_kind >= 4'd8 && ev_kind <= 4'd10)
      |=> !st_words[8*STW + 2]);

   p_clear_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clear && !ev_valid) |=> (sum_flags == '0));

   p_bad_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && unsupported && !sw_clear) |=> (bad_kind && $stable(sum_flags)));

   p_bad_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !bad_kind);
endmodule

bind exc_status_rec exc_status_rec_chk #(
   .NSLOT(NSLOT), .AW(AW), .DW(DW), .SUBW(SUBW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_valid  (ev_valid),
   .ev_kind   (ev_kind),
   .ev_mode   (ev_mode),
   .ev_addr   (ev_addr),
   .sw_clear  (sw_clear),
   .st_words  (st_words),
   .addr_regs (addr_regs),
   .sum_flags (sum_flags),
   .bad_kind  (bad_kind)
);

// File: tb/exc_status_rec_tb.sv
module exc_status_rec_tb;
   localparam int NSLOT = 16;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int SUBW  = 4;
   localparam int STW   = 9 + SUBW;

   // what codes for the scoreboard
   localparam int W_ST = 0, W_PC = 1, W_AD = 2, W_DATA = 3, W_SUM = 4, W_TRAP = 5, W_ERR = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 ev_valid = 1'b0;
   logic [3:0]           ev_kind = '0;
   logic [1:0]           ev_pipe = '0;
   logic [1:0]           ev_mode = '0;
   logic [AW-1:0]        ev_pc = '0;
   logic [AW-1:0]        ev_pkt_pc = '0;
   logic [AW-1:0]        ev_addr = '0;
   logic [2:0]           ev_len = '0;
   logic [4*DW-1:0]      ev_data;
   logic [SUBW-1:0]      ev_sub = '0;
   logic                 sw_clear = 1'b0;
   logic [NSLOT*STW-1:0] st_words;
   logic [NSLOT*AW-1:0]  pc_regs;
   logic [NSLOT*AW-1:0]  addr_regs;
   logic [4*DW-1:0]      data_regs;
   logic [NSLOT-1:0]     sum_flags;
   logic [SUBW-1:0]      trap_acc;
   logic                 bad_kind;

   assign ev_data = {32'hD000_0003, 32'hD000_0002, 32'hD000_0001, 32'hD000_0000};

   exc_status_rec u_dut (.*);

   always #2.5 clk = ~clk;

   typedef struct {
      int          due;
      int          what;
      int          idx;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] actual(int what, int idx);
      case (what)
         W_ST:   return 32'(st_words[idx*STW +: STW]);
         W_PC:   return pc_regs[idx*AW +: AW];
         W_AD:   return addr_regs[idx*AW +: AW];
         W_DATA: return data_regs[idx*DW +: DW];
         W_SUM:  return 32'(sum_flags);
         W_TRAP: return 32'(trap_acc);
         default: return 32'(bad_kind);
      endcase
   endfunction

   task automatic check_now(item_t it);
      logic [31:0] a;
      a = actual(it.what, it.idx);
      n_chk++;
      if (a !== it.exp) begin
         n_fail++;
         $display("FAIL %s what=%0d idx=%0d actual=%h expected=%h", it.tag, it.what, it.idx, a, it.exp);
      end
   endtask

   // monitor: compares queued expectations once their cycle arrives
   always @(posedge clk) begin
      #1;
      while (q.size() > 0 && q[0].due <= cyc) check_now(q.pop_front());
   end

   task automatic expect_next(int what, int idx, logic [31:0] exp, string tag);
      item_t it;
      it.due = cyc + 1; it.what = what; it.idx = idx; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic fire(logic [3:0] k, logic [1:0] p, logic [1:0] m, logic [31:0] pc,
                       logic [31:0] pk, logic [31:0] ad, logic [2:0] l, logic [3:0] s, logic c);
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = k; ev_pipe = p; ev_mode = m; ev_pc = pc;
      ev_pkt_pc = pk; ev_addr = ad; ev_len = l; ev_sub = s; sw_clear = c;
   endtask

   task automatic idle();
      @(negedge clk);
      ev_valid = 1'b0; sw_clear = 1'b0;
   endtask

   function automatic logic [31:0] stw(bit av, bit dv, int ix, int k, int s);
      return 32'(1 | (int'(av) << 1) | (int'(dv) << 2) | (ix << 3) | (k << 5) | (s << 9));
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      begin
         item_t it;
         it.due = cyc; it.idx = 0; it.tag = "reset";
         it.what = W_SUM;  it.exp = 0; check_now(it);
         it.what = W_ERR;  it.exp = 0; check_now(it);
         it.what = W_TRAP; it.exp = 0; check_now(it);
         it.what = W_ST;   it.exp = 0; check_now(it);
      end

      // R1 register exception, sub-code kept, PC written; R10 layout
      fire(4'd1, 2'd0, 2'd0, 32'h1000, 32'h0FF0, 32'h0, 3'd0, 4'd5, 1'b0);
      expect_next(W_ST, 0, stw(0, 0, 0, 1, 5), "R1 R10 precise status");
      expect_next(W_PC, 0, 32'h1000, "R1 precise pc");
      expect_next(W_SUM, 0, 32'h1, "R10 summary bit");
      idle();

      // R2 division from pipe 1 -> slot 1; R3 trap accumulation
      fire(4'd4, 2'd1, 2'd0, 32'h2000, 32'h0, 32'h0, 3'd0, 4'd3, 1'b0);
      expect_next(W_ST, 1, stw(0, 0, 0, 4, 0), "R2 division pipe1 slot1");
      expect_next(W_PC, 1, 32'h2000, "R2 division pc");
      expect_next(W_TRAP, 0, 32'h3, "R3 trap first");
      idle();

      // R2 division in alternate mode from pipe 1 -> slot 0
      fire(4'd4, 2'd1, 2'd1, 32'h3000, 32'h0, 32'h0, 3'd0, 4'd4, 1'b0);
      expect_next(W_ST, 0, stw(0, 0, 0, 4, 0), "R2 alt division slot0");
      expect_next(W_PC, 0, 32'h3000, "R2 alt division pc");
      expect_next(W_TRAP, 0, 32'h7, "R3 trap or");
      idle();

      // R2 commit from pipe 2 writes nothing
      fire(4'd5, 2'd2, 2'd0, 32'h4000, 32'h0, 32'h0, 3'd0, 4'd0, 1'b0);
      expect_next(W_SUM, 0, 32'h3, "R2 commit pipe2 no slot");
      expect_next(W_ERR, 0, 32'h0, "R2 commit pipe2 no error");
      idle();

      // R4 store error -> slot 14
      fire(4'd6, 2'd0, 2'd0, 32'h0, 32'h0, 32'hA0A0, 3'd0, 4'd0, 1'b0);
      expect_next(W_ST, 14, stw(0, 0, 0, 6, 0), "R4 store error slot14");
      idle();

      // R4 access error -> slot 15 with address
      fire(4'd7, 2'd1, 2'd0, 32'h0, 32'h0, 32'hBEEF, 3'd0, 4'd0, 1'b0);
      expect_next(W_ST, 15, stw(1, 0, 0, 7, 0), "R4 access error slot15");
      expect_next(W_AD, 15, 32'hBEEF, "R4 access error address");
      idle();

      // R5 R6 data access pipe0, length 1
      fire(4'd8, 2'd0, 2'd0, 32'h5000, 32'h0, 32'hC000, 3'd1, 4'd2, 1'b0);
      expect_next(W_ST, 8, stw(1, 1, 3, 8, 2), "R5 R6 data access slot8");
      expect_next(W_AD, 8, 32'hC000, "R5 address slot8");
      expect_next(W_PC, 8, 32'h5000, "R5 pc slot8");
      expect_next(W_DATA, 3, 32'hD000_0000, "R6 len1 word3");
      idle();

      // R5 R6 MMU miss pipe1, length 2
      fire(4'd9, 2'd1, 2'd0, 32'h6000, 32'h0, 32'hC100, 3'd2, 4'd7, 1'b0);
      expect_next(W_ST, 9, stw(1, 1, 2, 9, 0), "R5 R6 mmu miss slot9");
      expect_next(W_DATA, 2, 32'hD000_0000, "R6 len2 word2");
      expect_next(W_DATA, 3, 32'hD000_0001, "R6 len2 word3");
      idle();

      // R7 misalignment pipe3, length 0 clears data-valid
      fire(4'd10, 2'd3, 2'd0, 32'h6100, 32'h0, 32'hC200, 3'd0, 4'd0, 1'b0);
      expect_next(W_ST, 9, stw(1, 0, 0, 10, 0), "R7 data-valid cleared");
      idle();

      // R5 R6 alternate mode: slot 8, no data written
      fire(4'd10, 2'd1, 2'd1, 32'h6200, 32'h0, 32'hC300, 3'd4, 4'd0, 1'b0);
      expect_next(W_ST, 8, stw(1, 0, 0, 10, 0), "R5 R6 alt slot8 no data");
      expect_next(W_DATA, 0, 32'h0, "R6 alt data untouched");
      idle();

      // R1 alternate mode keeps slot 0 PC
      fire(4'd3, 2'd0, 2'd1, 32'h7000, 32'h0, 32'h0, 3'd0, 4'd9, 1'b0);
      expect_next(W_ST, 0, stw(0, 0, 0, 3, 0), "R1 other precise no sub");
      expect_next(W_PC, 0, 32'h3000, "R1 alt pc kept");
      idle();

      // R8 packet mode PC
      fire(4'd2, 2'd0, 2'd2, 32'h8000, 32'h7FF0, 32'h0, 3'd0, 4'd9, 1'b0);
      expect_next(W_ST, 0, stw(0, 0, 0, 2, 9), "R8 R1 iaccess status");
      expect_next(W_PC, 0, 32'h7FF0, "R8 packet pc");
      idle();

      // R6 length above 4 clamps to 4
      fire(4'd8, 2'd0, 2'd0, 32'h9000, 32'h0, 32'hC400, 3'd6, 4'd0, 1'b0);
      expect_next(W_ST, 8, stw(1, 1, 0, 8, 0), "R6 clamp status");
      expect_next(W_DATA, 0, 32'hD000_0000, "R6 clamp word0");
      expect_next(W_DATA, 3, 32'hD000_0003, "R6 clamp word3");
      idle();

      // R11 unsupported kind
      fire(4'd12, 2'd0, 2'd0, 32'hA000, 32'h0, 32'h0, 3'd0, 4'd0, 1'b0);
      expect_next(W_ERR, 0, 32'h1, "R11 error pulse");
      expect_next(W_SUM, 0, 32'hC303, "R11 flags unchanged");
      expect_next(W_ST, 0, stw(0, 0, 0, 2, 9), "R11 slot0 unchanged");
      idle();
      expect_next(W_ERR, 0, 32'h0, "R11 pulse one cycle");

      // R9 clear alone
      fire(4'd0, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0, 3'd0, 4'd0, 1'b1);
      ev_valid = 1'b0;
      expect_next(W_SUM, 0, 32'h0, "R9 flags zeroed");
      expect_next(W_ST, 0, stw(0, 0, 0, 2, 9) & ~32'h1, "R9 slot0 invalid");
      expect_next(W_ST, 15, stw(1, 0, 0, 7, 0) & ~32'h1, "R9 slot15 invalid");
      idle();

      // R9 clear with a same-cycle event
      fire(4'd1, 2'd0, 2'd0, 32'hB000, 32'h0, 32'h0, 3'd0, 4'd0, 1'b1);
      expect_next(W_ST, 0, stw(0, 0, 0, 1, 0), "R9 event beats clear");
      expect_next(W_SUM, 0, 32'h1, "R9 flag after clear+event");
      idle();

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule